// File: doc/BRIEF.md
# SPI Real-Time-Clock Burst Time Reader

This block is an SPI master that fetches the calendar time from an external real-time-clock device in a single transaction. A one-cycle start pulse makes it raise an active-high chip enable and wait a settle interval. It then shifts out the read address of the seconds register and clocks in seven consecutive register bytes, relying on the device's address auto-increment. After a second settle interval it drops the chip enable.

Each captured byte is masked and converted from packed BCD to binary. The hour byte is decoded in either 12-hour or 24-hour form. The weekday is rebased to start at zero, and the year is widened to a full four-digit value. All seven fields and a one-cycle done strobe are presented together.

The serial clock is derived from the system clock by a divider parameter. The default divider gives about 600 kHz from 100 MHz. The settle interval is a separate parameter; its default is about 10 µs.

Top module: `spi_rtc_time_rd`

## Requirements
- R1: After reset, chip enable is low, the serial clock is high, busy and done are low, and every time output is zero.
- R2: Within one frame, chip enable is high for exactly 64 serial-clock rising edges (8 address bits and 56 data bits). Done rises in the cycle after chip enable falls.
- R3: The only byte sent is the read address 0x00, so the data output stays low for the whole time chip enable is high.
- R4: SPI mode 3 is used: the serial clock idles high, the output changes on the falling edge, and the input is sampled on the rising edge. Bytes are most significant bit first. The seven data bytes are taken, in order, as seconds, minutes, hours, weekday, date, month and year.
- R5: Seconds and minutes are the BCD value of the byte ANDed with 0x7F.
- R6: When hour-byte bit 6 is 0, the hour is the BCD value of bits 5:0.
- R7: When hour-byte bit 6 is 1, the hour is the BCD value of bits 4:0. If bit 5 is 1, 11 is added to it; if bit 5 is 0, 1 is subtracted from it (modulo 64).
- R8: Date is the BCD value of the byte ANDed with 0x3F. Month is the BCD value of the byte ANDed with 0x1F.
- R9: Weekday is the BCD value of the byte ANDed with 0x07, minus 1, modulo 8.
- R10: Year is the BCD value of the full year byte plus 2000.
- R11: A start pulse while busy is ignored: it produces no extra frame and no extra done strobe.
- R12: Done is high for exactly one cycle. The time outputs change only in the cycle done is high, and all of them change together.
- R13: At least SETTLE_CYC system cycles separate the chip-enable rise from the first serial-clock fall. At least SETTLE_CYC cycles also separate the last serial-clock rise from the chip-enable fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to read the time |
| miso_i | input | 1 | Serial data from the clock device |
| ce_o | output | 1 | Chip enable, active high |
| sck_o | output | 1 | Serial clock, idles high |
| mosi_o | output | 1 | Serial data to the clock device |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle strobe, new time valid |
| sec_o | output | 7 | Seconds, binary |
| min_o | output | 7 | Minutes, binary |
| hour_o | output | 6 | Hours, binary |
| wday_o | output | 3 | Weekday, 0 to 6 |
| mday_o | output | 6 | Day of month, binary |
| mon_o | output | 5 | Month, binary |
| year_o | output | 12 | Full year |

## Verification
A start request can coincide with a transfer already in progress. The bench provokes this by pulsing start roughly a hundred cycles into a frame. It then judges the result over two full frame lengths: exactly one chip-enable rise, 64 clock edges and one done strobe must be seen, and the outputs must hold the first frame's decoded time. A second overlap occurs when the output registers load, which coincides with the final settle ending. The bench checks that, partway through the following frame, the outputs still hold the previous time.

// File: rtl/rtc_rd_pkg.sv
package rtc_rd_pkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_REGS  = 7;
  localparam logic [BYTE_W-1:0] READ_ADDR = 8'h00;

  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_XFER, ST_POST} seq_st_e;

  typedef struct packed {
    logic [6:0]  sec;
    logic [6:0]  min;
    logic [5:0]  hour;
    logic [2:0]  wday;
    logic [5:0]  mday;
    logic [4:0]  mon;
    logic [11:0] year;
  } rtc_time_t;

  function automatic logic [7:0] bcd2bin(input logic [7:0] b);
    return 8'(b[7:4]) * 8'd10 + 8'(b[3:0]);
  endfunction
endpackage

// File: rtl/spi_m3_byte.sv
module spi_m3_byte #(
  parameter int CLK_DIV = 84
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sck_o,
  output logic       mosi_o,
  output logic [7:0] rx_o,
  output logic       done_o
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic             active_q;
  logic [DIV_W-1:0] cnt_q;
  logic [2:0]       bit_q;
  logic [6:0]       tx_sh_q;

  // each bit: low half (drive), rising edge (sample), high half
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      bit_q    <= '0;
      tx_sh_q  <= '0;
      sck_o    <= 1'b1;
      mosi_o   <= 1'b0;
      rx_o     <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!active_q) begin
        if (go_i) begin
          active_q <= 1'b1;
          sck_o    <= 1'b0;
          mosi_o   <= tx_i[7];
          tx_sh_q  <= tx_i[6:0];
          cnt_q    <= '0;
          bit_q    <= '0;
        end
      end else if (cnt_q == DIV_W'(CLK_DIV - 1)) begin
        cnt_q <= '0;
        if (!sck_o) begin
          sck_o <= 1'b1;
          rx_o  <= {rx_o[6:0], miso_i};
        end else if (bit_q == 3'd7) begin
          active_q <= 1'b0;
          done_o   <= 1'b1;
        end else begin
          sck_o   <= 1'b0;
          bit_q   <= bit_q + 3'd1;
          mosi_o  <= tx_sh_q[6];
          tx_sh_q <= {tx_sh_q[5:0], 1'b0};
        end
      end else begin
        cnt_q <= cnt_q + DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/rtc_burst_seq.sv
module rtc_burst_seq
  import rtc_rd_pkg::*;
#(
  parameter int SETTLE_CYC = 1000
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic                          byte_done_i,
  input  logic [BYTE_W-1:0]             rx_i,
  output logic                          go_o,
  output logic [BYTE_W-1:0]             tx_o,
  output logic                          ce_o,
  output logic                          busy_o,
  output logic                          frame_done_o,
  output logic [NUM_REGS-1:0][BYTE_W-1:0] raw_o
);
  localparam int IDX_W = $clog2(NUM_REGS + 1);
  localparam int SET_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;

  seq_st_e          st_q;
  logic [IDX_W-1:0] idx_q;   // 0 = address byte, then data bytes
  logic [SET_W-1:0] set_q;

  assign tx_o   = READ_ADDR;
  assign busy_o = (st_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      idx_q        <= '0;
      set_q        <= '0;
      go_o         <= 1'b0;
      ce_o         <= 1'b0;
      frame_done_o <= 1'b0;
      raw_o        <= '0;
    end else begin
      go_o         <= 1'b0;
      frame_done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q  <= ST_PRE;
          ce_o  <= 1'b1;
          set_q <= '0;
        end
        ST_PRE: begin
          if (set_q == SET_W'(SETTLE_CYC - 1)) begin
            st_q  <= ST_XFER;
            idx_q <= '0;
            go_o  <= 1'b1;
          end else set_q <= set_q + SET_W'(1);
        end
        ST_XFER: if (byte_done_i) begin
          if (idx_q != '0) raw_o[idx_q - IDX_W'(1)] <= rx_i;
          if (idx_q == IDX_W'(NUM_REGS)) begin
            st_q  <= ST_POST;
            set_q <= '0;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
            go_o  <= 1'b1;
          end
        end
        ST_POST: begin
          if (set_q == SET_W'(SETTLE_CYC - 1)) begin
            st_q         <= ST_IDLE;
            ce_o         <= 1'b0;
            frame_done_o <= 1'b1;
          end else set_q <= set_q + SET_W'(1);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rtc_time_decode.sv
module rtc_time_decode
  import rtc_rd_pkg::*;
(
  input  logic [NUM_REGS-1:0][BYTE_W-1:0] raw_i,
  output rtc_time_t                       time_o
);
  logic [7:0] hb, h12, h24;

  always_comb begin
    hb  = raw_i[2];
    h12 = bcd2bin(hb & 8'h1F);
    h24 = bcd2bin(hb & 8'h3F);
    time_o.sec  = 7'(bcd2bin(raw_i[0] & 8'h7F));
    time_o.min  = 7'(bcd2bin(raw_i[1] & 8'h7F));
    if (hb[6]) time_o.hour = hb[5] ? 6'(h12 + 8'd11) : 6'(h12 - 8'd1);
    else       time_o.hour = 6'(h24);
    time_o.wday = 3'(bcd2bin(raw_i[3] & 8'h07) - 8'd1);
    time_o.mday = 6'(bcd2bin(raw_i[4] & 8'h3F));
    time_o.mon  = 5'(bcd2bin(raw_i[5] & 8'h1F));
    time_o.year = 12'(bcd2bin(raw_i[6])) + 12'd2000;
  end
endmodule

// File: rtl/spi_rtc_time_rd.sv
module spi_rtc_time_rd
  import rtc_rd_pkg::*;
#(
  parameter int CLK_DIV    = 84,
  parameter int SETTLE_CYC = 1000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        miso_i,
  output logic        ce_o,
  output logic        sck_o,
  output logic        mosi_o,
  output logic        busy_o,
  output logic        done_o,
  output logic [6:0]  sec_o,
  output logic [6:0]  min_o,
  output logic [5:0]  hour_o,
  output logic [2:0]  wday_o,
  output logic [5:0]  mday_o,
  output logic [4:0]  mon_o,
  output logic [11:0] year_o
);
  logic                          go, byte_done, frame_done;
  logic [BYTE_W-1:0]             tx, rx;
  logic [NUM_REGS-1:0][BYTE_W-1:0] raw;
  rtc_time_t                     dec, time_q;

  rtc_burst_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .byte_done_i(byte_done), .rx_i(rx), .go_o(go), .tx_o(tx),
    .ce_o(ce_o), .busy_o(busy_o), .frame_done_o(frame_done), .raw_o(raw)
  );

  spi_m3_byte #(.CLK_DIV(CLK_DIV)) u_phy (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(go), .tx_i(tx), .miso_i(miso_i),
    .sck_o(sck_o), .mosi_o(mosi_o), .rx_o(rx), .done_o(byte_done)
  );

  rtc_time_decode u_dec (.raw_i(raw), .time_o(dec));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_q <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= frame_done;
      if (frame_done) time_q <= dec;
    end
  end

  assign sec_o  = time_q.sec;
  assign min_o  = time_q.min;
  assign hour_o = time_q.hour;
  assign wday_o = time_q.wday;
  assign mday_o = time_q.mday;
  assign mon_o  = time_q.mon;
  assign year_o = time_q.year;
endmodule

// File: rtl/rtc_rd_chk.sv
module rtc_rd_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        ce_o,
  input logic        sck_o,
  input logic        mosi_o,
  input logic        busy_o,
  input logic        done_o,
  input logic [6:0]  sec_o,
  input logic [6:0]  min_o,
  input logic [5:0]  hour_o,
  input logic [2:0]  wday_o,
  input logic [5:0]  mday_o,
  input logic [4:0]  mon_o,
  input logic [11:0] year_o
);
  localparam int EDGES = (rtc_rd_pkg::NUM_REGS + 1) * rtc_rd_pkg::BYTE_W;

  logic       sck_d;
  logic [7:0] edge_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d    <= 1'b1;
      edge_cnt <= '0;
    end else begin
      sck_d <= sck_o;
      if (!ce_o) edge_cnt <= '0;
      else if (sck_o && !sck_d) edge_cnt <= edge_cnt + 8'd1;
    end
  end

  assert_sck_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_o |-> sck_o);
  assert_mosi_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_o |-> !mosi_o);
  assert_edge_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ce_o) |-> edge_cnt == 8'(EDGES));
  assert_done_after_ce_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!ce_o && $past(ce_o, 2)));
  assert_done_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_out_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable({sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o}));
  assert_start_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ce_o) |-> $past(!busy_o && start_i));
endmodule

bind spi_rtc_time_rd rtc_rd_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .ce_o(ce_o),
  .sck_o(sck_o), .mosi_o(mosi_o), .busy_o(busy_o), .done_o(done_o),
  .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
  .mday_o(mday_o), .mon_o(mon_o), .year_o(year_o)
);

// File: tb/sim_spi_rtc_time_rd.sv
`timescale 1ns/1ps
module sim_spi_rtc_time_rd;
  localparam int CLK_DIV = 3;
  localparam int SETTLE  = 5;
  localparam int NV      = 6;

  // raw bytes: {sec, min, hour, wday, date, month, year}
  localparam logic [55:0] RAW [NV] = '{
    56'h59_30_23_07_31_12_99,
    56'hD5_80_71_01_C1_E9_00,
    56'h00_45_49_FB_15_01_24,
    56'h07_01_52_04_28_02_50,
    56'h30_00_88_05_09_10_01,
    56'h01_59_72_02_01_07_10
  };
  // expected: {sec7, min7, hour6, wday3, mday6, mon5, year12}
  localparam logic [45:0] EXP [NV] = '{
    {7'd59, 7'd30, 6'd23, 3'd6, 6'd31, 5'd12, 12'd2099},
    {7'd55, 7'd0,  6'd22, 3'd0, 6'd1,  5'd9,  12'd2000},
    {7'd0,  7'd45, 6'd8,  3'd2, 6'd15, 5'd1,  12'd2024},
    {7'd7,  7'd1,  6'd11, 3'd3, 6'd28, 5'd2,  12'd2050},
    {7'd30, 7'd0,  6'd8,  3'd4, 6'd9,  5'd10, 12'd2001},
    {7'd1,  7'd59, 6'd23, 3'd1, 6'd1,  5'd7,  12'd2010}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, miso = 1'b0;
  logic ce, sck, mosi, busy, done;
  logic [6:0] sec, min; logic [5:0] hour; logic [2:0] wday;
  logic [5:0] mday; logic [4:0] mon; logic [11:0] year;

  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  spi_rtc_time_rd #(.CLK_DIV(CLK_DIV), .SETTLE_CYC(SETTLE)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .miso_i(miso),
    .ce_o(ce), .sck_o(sck), .mosi_o(mosi), .busy_o(busy), .done_o(done),
    .sec_o(sec), .min_o(min), .hour_o(hour), .wday_o(wday),
    .mday_o(mday), .mon_o(mon), .year_o(year)
  );

  // behavioural device: auto-incrementing register file
  logic [7:0] sreg [8];
  int rcnt = 0, addr = 0, ce_rises = 0, done_cnt = 0, mosi_hi = 0;
  time t_ce_up, t_first_fall, t_last_rise, t_ce_dn;
  bit first_fall_seen;

  always @(posedge ce) begin
    rcnt = 0; addr = 0; ce_rises++; first_fall_seen = 0; t_ce_up = $time;
  end
  always @(negedge ce) t_ce_dn = $time;
  always @(posedge sck) if (ce) begin
    if (rcnt < 8) addr = ((addr << 1) | int'(mosi)) & 8'hFF;
    rcnt++;
    t_last_rise = $time;
  end
  always @(negedge sck) if (ce) begin
    if (!first_fall_seen) begin first_fall_seen = 1; t_first_fall = $time; end
    if (rcnt >= 8) miso = sreg[(addr + (rcnt - 8) / 8) % 8][7 - (rcnt - 8) % 8];
  end
  always @(negedge clk) begin
    if (ce && mosi) mosi_hi++;
    if (done) done_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(input int v);
    for (int b = 0; b < 7; b++) sreg[b] = RAW[v][55 - 8*b -: 8];
    sreg[7] = 8'hEE;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic chk_time(input int v);
    chk(sec  == EXP[v][45:39], "R5 sec",  int'(sec),  int'(EXP[v][45:39]));
    chk(min  == EXP[v][38:32], "R5 min",  int'(min),  int'(EXP[v][38:32]));
    chk(hour == EXP[v][31:26], "R6/R7 hour", int'(hour), int'(EXP[v][31:26]));
    chk(wday == EXP[v][25:23], "R9 wday", int'(wday), int'(EXP[v][25:23]));
    chk(mday == EXP[v][22:17], "R8 mday", int'(mday), int'(EXP[v][22:17]));
    chk(mon  == EXP[v][16:12], "R8 mon",  int'(mon),  int'(EXP[v][16:12]));
    chk(year == EXP[v][11:0],  "R10 year", int'(year), int'(EXP[v][11:0]));
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!ce && sck && !busy && !done, "R1 idle pins", {ce, sck, busy, done}, 4'b0100);
    chk({sec, min, hour, wday, mday, mon, year} == '0, "R1 outputs", int'(year), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      load(v);
      ce_rises = 0; mosi_hi = 0; done_cnt = 0;
      pulse_start();
      chk(busy && ce, "R2 ce on start", int'(ce), 1);
      if (v > 0) begin
        repeat (100) @(negedge clk);
        chk(sec == EXP[v-1][45:39] && year == EXP[v-1][11:0], "R12 hold mid-frame",
            int'(year), int'(EXP[v-1][11:0]));
      end
      wait_done();
      chk(!ce && !busy, "R2 ce low at done", int'(ce), 0);
      chk(rcnt == 64, "R2 edge count", rcnt, 64);
      chk(addr == 0, "R3 address byte", addr, 0);
      chk(mosi_hi == 0, "R3 mosi low", mosi_hi, 0);
      chk(t_first_fall - t_ce_up >= SETTLE * 10, "R13 lead settle",
          int'(t_first_fall - t_ce_up), SETTLE * 10);
      chk(t_ce_dn - t_last_rise >= SETTLE * 10, "R13 trail settle",
          int'(t_ce_dn - t_last_rise), SETTLE * 10);
      chk_time(v);   // R4 MSB-first order via decoded fields
      @(negedge clk);
      chk(!done && done_cnt == 1, "R12 done one cycle", done_cnt, 1);
      chk(sck, "R4 sck idles high", int'(sck), 1);
    end

    // R11: start while busy
    load(0);
    ce_rises = 0; done_cnt = 0;
    pulse_start();
    repeat (100) @(negedge clk);
    chk(busy, "R11 busy mid-frame", int'(busy), 1);
    pulse_start();
    repeat (2 * (2 * SETTLE + 8 * 8 * 2 * CLK_DIV + 40)) @(negedge clk);
    chk(ce_rises == 1, "R11 single frame", ce_rises, 1);
    chk(done_cnt == 1, "R11 single done", done_cnt, 1);
    chk(!busy && !ce, "R11 idle after", int'(busy), 0);
    chk_time(0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule